// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block turns a run-time element count `n` into a sequence of vector segments for a vector unit. The unit's registers hold at most `MVL` elements. A single start pulse with `n` launches the sequence. The block then offers one segment descriptor at a time on a valid/ready channel. Each descriptor carries the index of the segment's first element, the value to load into the vector-length register, and a flag on the final segment. The vector-length value governs every vector operation of that segment, loads and stores included.

The odd-sized piece, `n mod MVL`, goes out first. Every later piece is a full `MVL` elements. The sequence therefore has `floor(n/MVL) + 1` segments. When `n` is an exact multiple of `MVL`, the leading piece is empty. The `SKIP_EMPTY` parameter chooses between two behaviours for that case: issue the empty piece with length zero, or drop it. `MVL` must be a power of two, so the remainder is a bit mask and the quotient is a shift. No divider is involved.

Top module: `vlseq_top`

## Requirements
- R1: With `SKIP_EMPTY=0`, the first segment has start index 0 and length `n mod MVL`.
- R2: Every segment after the first has length `MVL`.
- R3: The sequence has `floor(n/MVL) + 1` segments (`SKIP_EMPTY=0`). `seg_last_o` is 1 on the final segment only.
- R4: Each segment's start index is the previous segment's start index plus the previous segment's length.
- R5: `seg_len_o` never exceeds `MVL`.
- R6: While `seg_valid_o` is 1 and `seg_ready_i` is 0, the start index, length and last flag hold. The block advances only on a cycle with valid and ready both 1.
- R7: A start pulse that arrives while `busy_o` is 1 has no effect on the sequence in progress.
- R8: `busy_o` rises in the cycle after an accepted start. It falls in the cycle after the final handshake. In that same cycle `done_o` is 1 for exactly one cycle.
- R9: With `SKIP_EMPTY=0`, a multiple of `MVL` (zero included) produces a first segment of length 0 at index 0. `n=0` gives one zero-length segment, flagged last.
- R10: With `SKIP_EMPTY=1`, an empty leading piece is not issued, so a multiple of `MVL` gives `n/MVL` full segments. `n=0` issues no segment: `done_o` pulses in the cycle after the start, and `busy_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only when idle |
| count_i | input | CNT_W | Total element count `n`, sampled with `start_i` |
| seg_valid_o | output | 1 | A segment descriptor is on offer |
| seg_ready_i | input | 1 | Consumer takes the descriptor |
| seg_start_o | output | CNT_W | Index of the segment's first element |
| seg_len_o | output | $clog2(MVL)+1 | Vector-length value for the segment |
| seg_last_o | output | 1 | Final segment of the sequence |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the final handshake |

## Verification
The bench builds two copies of the block, both with `MVL=8` and `CNT_W=10`. One has `SKIP_EMPTY=0` and the other `SKIP_EMPTY=1`, so both treatments of an empty leading piece are checked against the same counts. The small `MVL` gives remainder, exact-multiple and zero counts within a few segments. The 10-bit count reaches the widest input, `n=1023`, which produces 128 segments and exercises the carry of the start index up to its top bits.

// File: rtl/vlseq_pkg.sv
package vlseq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1
    } seq_state_e;

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    function automatic int unsigned len_width(input int unsigned mvl);
        return $clog2(mvl) + 1;
    endfunction

endpackage

// File: rtl/vlseq_plan.sv
module vlseq_plan #(
    parameter int unsigned MVL        = 64,
    parameter int unsigned CNT_W      = 16,
    parameter bit          SKIP_EMPTY = 1'b0,
    localparam int unsigned LOG2      = $clog2(MVL),
    localparam int unsigned LEN_W     = LOG2 + 1,
    localparam int unsigned QUO_W     = CNT_W - LOG2,
    localparam int unsigned SEG_W     = QUO_W + 1
) (
    input  logic [CNT_W-1:0] count_i,
    output logic [LEN_W-1:0] first_len_o,
    output logic [SEG_W-1:0] seg_total_o
);

    logic [LOG2-1:0]  rem;
    logic [QUO_W-1:0] quo;
    logic             rem_zero;
    logic             drop_first;

    // power-of-two length: remainder is a mask, quotient a shift
    assign rem        = count_i[LOG2-1:0];
    assign quo        = count_i[CNT_W-1:LOG2];
    assign rem_zero   = (rem == '0);

    generate
        if (SKIP_EMPTY) begin : g_skip
            assign drop_first = rem_zero;
        end else begin : g_keep
            assign drop_first = 1'b0;
        end
    endgenerate

    always_comb begin
        if (drop_first) begin
            first_len_o = LEN_W'(MVL);
            seg_total_o = {1'b0, quo};
        end else begin
            first_len_o = {1'b0, rem};
            seg_total_o = {1'b0, quo} + SEG_W'(1);
        end
    end

endmodule

// File: rtl/vlseq_cursor.sv
module vlseq_cursor #(
    parameter int unsigned MVL   = 64,
    parameter int unsigned CNT_W = 16,
    localparam int unsigned LOG2  = $clog2(MVL),
    localparam int unsigned LEN_W = LOG2 + 1,
    localparam int unsigned SEG_W = CNT_W - LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             adv_i,
    input  logic [LEN_W-1:0] first_len_i,
    input  logic [SEG_W-1:0] seg_total_i,
    output logic [CNT_W-1:0] idx_o,
    output logic [LEN_W-1:0] len_o,
    output logic             last_o
);

    logic [CNT_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q;
    logic [SEG_W-1:0] left_q;
    logic [CNT_W-1:0] len_ext;

    assign len_ext = {{(CNT_W-LEN_W){1'b0}}, len_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            len_q  <= '0;
            left_q <= '0;
        end else if (load_i) begin
            idx_q  <= '0;
            len_q  <= first_len_i;
            left_q <= seg_total_i;
        end else if (adv_i) begin
            idx_q  <= idx_q + len_ext;
            len_q  <= LEN_W'(MVL);
            left_q <= left_q - SEG_W'(1);
        end
    end

    assign idx_o  = idx_q;
    assign len_o  = len_q;
    assign last_o = (left_q == SEG_W'(1));

endmodule

// File: rtl/vlseq_ctrl.sv
module vlseq_ctrl
    import vlseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic none_i,
    input  logic hs_i,
    input  logic last_i,
    output logic load_o,
    output logic busy_o,
    output logic done_o
);

    seq_state_e state_q, state_d;
    logic       done_q, done_d;

    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        load_o  = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_i) begin
                    load_o = 1'b1;
                    if (none_i) begin
                        done_d = 1'b1;
                    end else begin
                        state_d = SEQ_RUN;
                    end
                end
            end
            SEQ_RUN: begin
                if (hs_i && last_i) begin
                    state_d = SEQ_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    assign busy_o = (state_q == SEQ_RUN);
    assign done_o = done_q;

endmodule

// File: rtl/vlseq_top.sv
module vlseq_top
    import vlseq_pkg::*;
#(
    parameter int unsigned MVL        = 64,
    parameter int unsigned CNT_W      = 16,
    parameter bit          SKIP_EMPTY = 1'b0,
    localparam int unsigned LOG2      = $clog2(MVL),
    localparam int unsigned LEN_W     = LOG2 + 1,
    localparam int unsigned SEG_W     = CNT_W - LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             seg_valid_o,
    input  logic             seg_ready_i,
    output logic [CNT_W-1:0] seg_start_o,
    output logic [LEN_W-1:0] seg_len_o,
    output logic             seg_last_o,
    output logic             busy_o,
    output logic             done_o
);

    typedef struct packed {
        logic [CNT_W-1:0] start;
        logic [LEN_W-1:0] len;
        logic             last;
    } seg_desc_t;

    initial begin
        if (!is_pow2(MVL) || MVL < 2) $error("MVL must be a power of two of at least 2");
        if (CNT_W <= LEN_W) $error("CNT_W must exceed the length field width");
    end

    logic [LEN_W-1:0] first_len;
    logic [SEG_W-1:0] seg_total;
    logic             load;
    logic             busy;
    logic             hs;
    seg_desc_t        desc;

    vlseq_plan #(
        .MVL        (MVL),
        .CNT_W      (CNT_W),
        .SKIP_EMPTY (SKIP_EMPTY)
    ) u_plan (
        .count_i     (count_i),
        .first_len_o (first_len),
        .seg_total_o (seg_total)
    );

    vlseq_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .none_i  (seg_total == '0),
        .hs_i    (hs),
        .last_i  (desc.last),
        .load_o  (load),
        .busy_o  (busy),
        .done_o  (done_o)
    );

    vlseq_cursor #(
        .MVL   (MVL),
        .CNT_W (CNT_W)
    ) u_cursor (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .adv_i       (hs),
        .first_len_i (first_len),
        .seg_total_i (seg_total),
        .idx_o       (desc.start),
        .len_o       (desc.len),
        .last_o      (desc.last)
    );

    assign hs          = busy && seg_ready_i;
    assign seg_valid_o = busy;
    assign busy_o      = busy;
    assign seg_start_o = desc.start;
    assign seg_len_o   = desc.len;
    assign seg_last_o  = desc.last;

endmodule

// File: rtl/vlseq_chk.sv
module vlseq_chk #(
    parameter int unsigned MVL        = 64,
    parameter int unsigned CNT_W      = 16,
    parameter bit          SKIP_EMPTY = 1'b0,
    localparam int unsigned LOG2      = $clog2(MVL),
    localparam int unsigned LEN_W     = LOG2 + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [CNT_W-1:0] count_i,
    input logic             seg_valid_o,
    input logic             seg_ready_i,
    input logic [CNT_W-1:0] seg_start_o,
    input logic [LEN_W-1:0] seg_len_o,
    input logic             seg_last_o,
    input logic             busy_o,
    input logic             done_o
);

    logic [CNT_W-1:0] cnt_prev;
    logic [LEN_W-1:0] exp_first;
    logic             hs;

    always_ff @(posedge clk) begin
        if (rst) cnt_prev <= '0;
        else     cnt_prev <= count_i;
    end

    always_comb begin
        exp_first = {1'b0, cnt_prev[LOG2-1:0]};
        if (SKIP_EMPTY && cnt_prev[LOG2-1:0] == '0) exp_first = LEN_W'(MVL);
    end

    assign hs = seg_valid_o && seg_ready_i;

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        seg_valid_o |-> seg_len_o <= LEN_W'(MVL)); // R5
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        seg_valid_o && !seg_ready_i |=> seg_valid_o && $stable(seg_start_o) && $stable(seg_len_o) && $stable(seg_last_o)); // R6
    AST_FULL_LATER: assert property (@(posedge clk) disable iff (rst)
        hs && !seg_last_o |=> seg_len_o == LEN_W'(MVL)); // R2
    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
        hs && !seg_last_o |=> seg_start_o == $past(seg_start_o) + CNT_W'($past(seg_len_o))); // R4
    AST_FIRST_SEG: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> seg_start_o == '0 && seg_len_o == exp_first); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        hs && seg_last_o |=> done_o && !busy_o); // R8
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        busy_o && !(hs && seg_last_o) |=> busy_o && !done_o); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

endmodule

bind vlseq_top vlseq_chk #(
    .MVL        (MVL),
    .CNT_W      (CNT_W),
    .SKIP_EMPTY (SKIP_EMPTY)
) u_vlseq_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .count_i     (count_i),
    .seg_valid_o (seg_valid_o),
    .seg_ready_i (seg_ready_i),
    .seg_start_o (seg_start_o),
    .seg_len_o   (seg_len_o),
    .seg_last_o  (seg_last_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/tb_vlseq_top.sv
module tb_vlseq_top;

    localparam int MVL   = 8;
    localparam int CNT_W = 10;
    localparam int LEN_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_a = 1'b0, start_b = 1'b0;
    logic [CNT_W-1:0] count = '0;
    logic ready = 1'b0;
    logic sel = 1'b0;

    logic a_valid, a_last, a_busy, a_done, b_valid, b_last, b_busy, b_done;
    logic [CNT_W-1:0] a_start, b_start;
    logic [LEN_W-1:0] a_len, b_len;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    vlseq_top #(.MVL(MVL), .CNT_W(CNT_W), .SKIP_EMPTY(1'b0)) dut (
        .clk(clk), .rst(rst), .start_i(start_a), .count_i(count),
        .seg_valid_o(a_valid), .seg_ready_i(ready && !sel),
        .seg_start_o(a_start), .seg_len_o(a_len), .seg_last_o(a_last),
        .busy_o(a_busy), .done_o(a_done)
    );

    vlseq_top #(.MVL(MVL), .CNT_W(CNT_W), .SKIP_EMPTY(1'b1)) dut_skip (
        .clk(clk), .rst(rst), .start_i(start_b), .count_i(count),
        .seg_valid_o(b_valid), .seg_ready_i(ready && sel),
        .seg_start_o(b_start), .seg_len_o(b_len), .seg_last_o(b_last),
        .busy_o(b_busy), .done_o(b_done)
    );

    wire             m_valid = sel ? b_valid : a_valid;
    wire             m_last  = sel ? b_last  : a_last;
    wire             m_busy  = sel ? b_busy  : a_busy;
    wire             m_done  = sel ? b_done  : a_done;
    wire [CNT_W-1:0] m_start = sel ? b_start : a_start;
    wire [LEN_W-1:0] m_len   = sel ? b_len   : a_len;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // drive one whole sequence and check every descriptor against the count
    task automatic run_seq(input bit skip, input int n, input bit stall, input bit poke);
        int rem = n % MVL;
        int q   = n / MVL;
        bit drop = skip && (rem == 0);
        int nseg = q + (drop ? 0 : 1);
        int exp_start = 0;
        sel = skip;
        count = CNT_W'(n);
        if (skip) start_b = 1'b1; else start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        start_b = 1'b0;
        if (nseg == 0) begin
            chk(m_done == 1'b1, "R10", int'(m_done), 1);
            chk(m_valid == 1'b0, "R10", int'(m_valid), 0);
            chk(m_busy == 1'b0, "R10", int'(m_busy), 0);
            @(negedge clk);
            chk(m_done == 1'b0, "R8", int'(m_done), 0);
            return;
        end
        for (int k = 0; k < nseg; k++) begin
            int exp_len = (k == 0 && !drop) ? rem : MVL;
            bit exp_last = (k == nseg - 1);
            string lreq = (k != 0) ? "R2" : (exp_len == 0 ? "R9" : (drop ? "R10" : "R1"));
            int s0, l0, t0;
            chk(m_valid == 1'b1, "R3", int'(m_valid), 1);
            chk(m_busy == 1'b1, "R8", int'(m_busy), 1);
            chk(m_done == 1'b0, "R8", int'(m_done), 0);
            chk(int'(m_start) == exp_start, "R4", int'(m_start), exp_start);
            chk(int'(m_len) == exp_len, lreq, int'(m_len), exp_len);
            chk(int'(m_len) <= MVL, "R5", int'(m_len), MVL);
            chk(m_last == exp_last, "R3", int'(m_last), int'(exp_last));
            if (stall) begin
                s0 = int'(m_start); l0 = int'(m_len); t0 = int'(m_last);
                ready = 1'b0;
                if (poke && k == 0) begin
                    count = CNT_W'(3);
                    if (skip) start_b = 1'b1; else start_a = 1'b1;
                end
                @(negedge clk);
                start_a = 1'b0;
                start_b = 1'b0;
                count = CNT_W'(n);
                chk(m_valid == 1'b1, "R6", int'(m_valid), 1);
                chk(int'(m_start) == s0, "R6", int'(m_start), s0);
                chk(int'(m_len) == l0, (poke && k == 0) ? "R7" : "R6", int'(m_len), l0);
                chk(int'(m_last) == t0, "R6", int'(m_last), t0);
            end
            ready = 1'b1;
            @(negedge clk);
            ready = 1'b0;
            exp_start += exp_len;
        end
        chk(m_done == 1'b1, "R8", int'(m_done), 1);
        chk(m_busy == 1'b0, "R8", int'(m_busy), 0);
        chk(m_valid == 1'b0, "R3", int'(m_valid), 0);
        @(negedge clk);
        chk(m_done == 1'b0, "R8", int'(m_done), 0);
    endtask

    task automatic t_reset();
        chk(a_valid == 1'b0 && b_valid == 1'b0, "R8", int'(a_valid | b_valid), 0);
        chk(a_busy == 1'b0 && b_busy == 1'b0, "R8", int'(a_busy | b_busy), 0);
        chk(a_done == 1'b0 && b_done == 1'b0, "R8", int'(a_done | b_done), 0);
    endtask

    task automatic t_remainder_first();   // R1 R2 R3 R4
        run_seq(1'b0, 20, 1'b0, 1'b0);
        run_seq(1'b0, 5, 1'b0, 1'b0);
        run_seq(1'b0, 31, 1'b0, 1'b0);
    endtask

    task automatic t_exact_multiple();    // R9
        run_seq(1'b0, 16, 1'b0, 1'b0);
        run_seq(1'b0, 0, 1'b0, 1'b0);
    endtask

    task automatic t_backpressure();      // R6 R7
        run_seq(1'b0, 27, 1'b1, 1'b1);
        run_seq(1'b1, 24, 1'b1, 1'b1);
    endtask

    task automatic t_skip_empty();        // R10
        run_seq(1'b1, 16, 1'b0, 1'b0);
        run_seq(1'b1, 0, 1'b0, 1'b0);
        run_seq(1'b1, 13, 1'b0, 1'b0);
    endtask

    task automatic t_widest();            // R4 R5
        run_seq(1'b0, 1023, 1'b0, 1'b0);
        run_seq(1'b1, 1016, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_remainder_first();
        t_exact_multiple();
        t_backpressure();
        t_skip_empty();
        t_widest();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule